// File: doc/BRIEF.md
# Nested-priority interrupt collector

This block merges level-sensitive requests from a parameterised set of sources into one interrupt line toward the CPU. Each source has a small configuration word that holds an enable bit and a priority. Each cycle an arbiter picks the most urgent enabled, pending source whose priority is strictly above every level currently in service. The chosen source number is registered and readable as a vector code. When nothing qualifies, the reserved code 0x7F is reported instead.

Software services a request in two steps. A write of any value to the vector register drops the interrupt line at once and marks the selected source's priority level as in service. Only a strictly more urgent request can then interrupt again. When the handler finishes, software writes a one-hot mask to the level-acknowledge register to retire that level, and a request still waiting at that level is selected again. All access goes through a simple 32-bit register bus with a single write strobe and a combinational read port. No list of pending sources is exposed.

Top module: `nest_irq_collector`

## Requirements
- R1: After reset the interrupt line is low, the status register (offset 0x400) reads vector 0x7F, and every source configuration word reads 0.
- R2: The configuration word of source n sits at byte address n*0x10, with the enable in bit 2 and the priority in bits 1:0. A write at +0x0 replaces the word. A write at +0x4 sets each bit written as 1, and a write at +0x8 clears each bit written as 1. Zero bits written to either alias leave the word unchanged. The word reads back at +0x0.
- R3: With no level in service, an enabled source whose request is high raises the interrupt line one clock after the request. The status register then names it in bits 6:0. A request from a disabled source has no effect.
- R4: Among qualifying sources the highest priority value wins. Among equal priorities the lowest source number wins.
- R5: When no source qualifies, the status register reads 0x7F and the interrupt line is low.
- R6: A write of any value to the vector register (0x410) drives the interrupt line low on the clock edge of the write. It also marks the priority level of the source in the status register as in service.
- R7: While a level is in service, requests at that level or below neither raise the line nor appear in the status register. A request at a strictly higher level does raise the line.
- R8: A write to the level-acknowledge register (0x420) retires each level whose bit is set (bit n stands for priority n) and leaves the other levels in service. A request still waiting at a retired level is selected again.
- R9: A vector-register write while the status register reads 0x7F marks no level as in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 64 | Level-sensitive request, one bit per source |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Interrupt line toward the CPU |

## Verification
The bench targets the tie between equal-priority sources and a disabled source that is pending next to enabled ones. A design with the wrong tie rule would name a higher-numbered source, and one that ignored the enable bit would raise the line for a masked source. It also nests two levels and retires them in reverse order, with requests still waiting at the lower level. A design that cleared every in-service level on one acknowledge, or compared against the wrong level, would raise the line too early or never raise it again. Finally, it issues a vector write while nothing qualifies and follows it with a lowest-priority request. A design that marked a level for the reserved code would then keep that request masked.

// File: rtl/nic_pkg.sv
package nic_pkg;

    localparam int unsigned DEF_NUM_SRC = 64;
    localparam int unsigned DEF_PRIO_W  = 2;
    localparam int unsigned DEF_ADDR_W  = 12;
    localparam int unsigned BUS_W       = 32;

    // Alias selected by address bits 3:2 inside a source window
    typedef enum logic [1:0] {
        ALIAS_BASE = 2'd0,
        ALIAS_SET  = 2'd1,
        ALIAS_CLR  = 2'd2,
        ALIAS_NONE = 2'd3
    } alias_e;

    // Control register offsets above the source windows
    localparam int unsigned OFS_STATUS = 'h00;
    localparam int unsigned OFS_VECTOR = 'h10;
    localparam int unsigned OFS_LVLACK = 'h20;

endpackage

// File: rtl/nic_src_bank.sv
module nic_src_bank
    import nic_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_NUM_SRC,
    parameter int unsigned PRIO_W  = DEF_PRIO_W,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC),
    localparam int unsigned CFG_W  = PRIO_W + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  alias_e                         wr_op,
    input  logic [CFG_W-1:0]               wr_bits,
    output logic [NUM_SRC-1:0][CFG_W-1:0]  cfg_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0][CFG_W-1:0] cfg;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            unique case (wr_op)
                ALIAS_BASE: bank_d.cfg[wr_idx] = wr_bits;
                ALIAS_SET:  bank_d.cfg[wr_idx] = bank_q.cfg[wr_idx] | wr_bits;
                ALIAS_CLR:  bank_d.cfg[wr_idx] = bank_q.cfg[wr_idx] & ~wr_bits;
                default:    bank_d.cfg[wr_idx] = bank_q.cfg[wr_idx];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign cfg_o = bank_q.cfg;

    p_base_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == ALIAS_BASE) |=> cfg_o[$past(wr_idx)] == $past(wr_bits));

    p_set_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == ALIAS_SET) |=>
            (cfg_o[$past(wr_idx)] & $past(wr_bits)) == $past(wr_bits));

    p_clr_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == ALIAS_CLR) |=> (cfg_o[$past(wr_idx)] & $past(wr_bits)) == '0);

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_NUM_SRC,
    parameter int unsigned PRIO_W  = DEF_PRIO_W,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC),
    localparam int unsigned CFG_W  = PRIO_W + 1,
    localparam int unsigned NUM_LVL = 1 << PRIO_W
) (
    input  logic [NUM_SRC-1:0]             req,
    input  logic [NUM_SRC-1:0][CFG_W-1:0]  cfg,
    input  logic [NUM_LVL-1:0]             in_svc,
    output logic                           win_valid,
    output logic [IDX_W-1:0]               win_idx
);

    logic [NUM_LVL-1:0] lvl_ok;
    logic [NUM_SRC-1:0] elig;

    // A level may interrupt only if it and every level above it are idle
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        assign lvl_ok[l] = ~|(in_svc >> l);
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign elig[s] = req[s] & cfg[s][PRIO_W] & lvl_ok[cfg[s][PRIO_W-1:0]];
    end

    logic [PRIO_W-1:0] best_prio;

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        best_prio = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (elig[s] && (!win_valid || cfg[s][PRIO_W-1:0] > best_prio)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(s);
                best_prio = cfg[s][PRIO_W-1:0];
            end
        end
    end

endmodule

// File: rtl/nic_service.sv
module nic_service
    import nic_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_NUM_SRC,
    parameter int unsigned PRIO_W  = DEF_PRIO_W,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC),
    localparam int unsigned VEC_W  = IDX_W + 1,
    localparam int unsigned NUM_LVL = 1 << PRIO_W,
    localparam logic [VEC_W-1:0] NONE_VEC = {VEC_W{1'b1}}
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            win_valid,
    input  logic [IDX_W-1:0]                win_idx,
    input  logic                            vec_wr,
    input  logic                            ack_wr,
    input  logic [NUM_LVL-1:0]              ack_bits,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0]  src_prio,
    output logic [NUM_LVL-1:0]              in_svc_o,
    output logic [VEC_W-1:0]                vec_o,
    output logic                            irq_o
);

    typedef struct packed {
        logic [NUM_LVL-1:0] in_svc;
        logic [VEC_W-1:0]   vec;
        logic               irq;
    } svc_t;

    svc_t svc_d, svc_q;
    logic [PRIO_W-1:0] cur_lvl;
    logic              cur_real;

    assign cur_real = (svc_q.vec != NONE_VEC);
    assign cur_lvl  = src_prio[svc_q.vec[IDX_W-1:0]];

    always_comb begin
        svc_d     = svc_q;
        svc_d.vec = win_valid ? {1'b0, win_idx} : NONE_VEC;
        svc_d.irq = win_valid && !vec_wr;
        if (vec_wr && cur_real) begin
            svc_d.in_svc[cur_lvl] = 1'b1;
        end
        if (ack_wr) begin
            svc_d.in_svc = svc_d.in_svc & ~ack_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            svc_q.in_svc <= '0;
            svc_q.vec    <= NONE_VEC;
            svc_q.irq    <= 1'b0;
        end else begin
            svc_q <= svc_d;
        end
    end

    assign in_svc_o = svc_q.in_svc;
    assign vec_o    = svc_q.vec;
    assign irq_o    = svc_q.irq;

    p_vec_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_wr |=> !irq_o);

    p_vec_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_wr && cur_real) |=> in_svc_o[$past(cur_lvl)]);

    p_irq_named_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> vec_o != NONE_VEC);

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_ack_chk
        p_ack_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_wr && ack_bits[l]) |=> !in_svc_o[l]);
    end

endmodule

// File: rtl/nest_irq_collector.sv
module nest_irq_collector
    import nic_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_NUM_SRC,
    parameter int unsigned PRIO_W  = DEF_PRIO_W,
    parameter int unsigned ADDR_W  = DEF_ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic               irq
);

    localparam int unsigned IDX_W   = $clog2(NUM_SRC);
    localparam int unsigned CFG_W   = PRIO_W + 1;
    localparam int unsigned VEC_W   = IDX_W + 1;
    localparam int unsigned NUM_LVL = 1 << PRIO_W;
    localparam int unsigned WIN_SH  = IDX_W + 4;
    localparam logic [ADDR_W-1:0] CTRL_BASE = ADDR_W'(NUM_SRC * 16);
    localparam logic [ADDR_W-1:0] A_STATUS  = CTRL_BASE + ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_VECTOR  = CTRL_BASE + ADDR_W'(OFS_VECTOR);
    localparam logic [ADDR_W-1:0] A_LVLACK  = CTRL_BASE + ADDR_W'(OFS_LVLACK);

    logic                          in_src;
    logic [IDX_W-1:0]              sel_idx;
    alias_e                        sel_alias;
    logic                          cfg_wr;
    logic                          vec_wr;
    logic                          ack_wr;
    logic [NUM_SRC-1:0][CFG_W-1:0] cfg;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    logic                          win_valid;
    logic [IDX_W-1:0]              win_idx;
    logic [NUM_LVL-1:0]            in_svc;
    logic [VEC_W-1:0]              vec;

    assign in_src    = (bus_addr >> WIN_SH) == '0;
    assign sel_idx   = bus_addr[WIN_SH-1:4];
    assign sel_alias = alias_e'(bus_addr[3:2]);
    assign cfg_wr    = bus_wr && in_src && (sel_alias != ALIAS_NONE);
    assign vec_wr    = bus_wr && (bus_addr == A_VECTOR);
    assign ack_wr    = bus_wr && (bus_addr == A_LVLACK);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_prio
        assign prio[s] = cfg[s][PRIO_W-1:0];
    end

    nic_src_bank #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_idx  (sel_idx),
        .wr_op   (sel_alias),
        .wr_bits (bus_wdata[CFG_W-1:0]),
        .cfg_o   (cfg)
    );

    nic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) i_arb (
        .req       (src_req),
        .cfg       (cfg),
        .in_svc    (in_svc),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    nic_service #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) i_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .vec_wr    (vec_wr),
        .ack_wr    (ack_wr),
        .ack_bits  (bus_wdata[NUM_LVL-1:0]),
        .src_prio  (prio),
        .in_svc_o  (in_svc),
        .vec_o     (vec),
        .irq_o     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (in_src && sel_alias == ALIAS_BASE) begin
            bus_rdata[CFG_W-1:0] = cfg[sel_idx];
        end else if (bus_addr == A_STATUS) begin
            bus_rdata[VEC_W-1:0] = vec;
        end
    end

endmodule

// File: tb/test_nest_irq_collector.sv
module test_nest_irq_collector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_req = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    nest_irq_collector i_nest_irq_collector (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    localparam logic [11:0] A_STATUS = 12'h400;
    localparam logic [11:0] A_VECTOR = 12'h410;
    localparam logic [11:0] A_LVLACK = 12'h420;

    typedef struct packed {
        logic [63:0] req;
        logic [6:0]  vec;
        logic        irq;
    } step_t;

    // Sources configured with priority n%4, all enabled except source 7
    localparam step_t STEPS [9] = '{
        '{64'h0000_0000_0000_0020, 7'h05, 1'b1},
        '{64'h0000_0000_0000_0060, 7'h06, 1'b1},
        '{64'h0000_0000_0000_0088, 7'h03, 1'b1},
        '{64'h0000_0000_0000_0080, 7'h7F, 1'b0},
        '{64'h0000_0000_0000_0444, 7'h02, 1'b1},
        '{64'h8000_0000_0000_0800, 7'h0B, 1'b1},
        '{64'h0000_0000_0000_0000, 7'h7F, 1'b0},
        '{64'h0000_0100_0000_0011, 7'h00, 1'b1},
        '{64'h1000_0002_0000_0000, 7'h21, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        idle(2);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 irq", 32'(irq), 32'd0);
        rd(A_STATUS, r); chk("R1 status", r, 32'h7F);
        rd(12'h050, r);  chk("R1 cfg", r, 32'h0);

        // R2 register access through base, set and clear aliases
        wr(12'h050, 32'h6);  rd(12'h050, r); chk("R2 base", r, 32'h6);
        wr(12'h054, 32'h1);  rd(12'h050, r); chk("R2 set", r, 32'h7);
        wr(12'h058, 32'h4);  rd(12'h050, r); chk("R2 clr", r, 32'h3);
        wr(12'h054, 32'h0);  rd(12'h050, r); chk("R2 set zero", r, 32'h3);
        wr(12'h058, 32'h0);  rd(12'h050, r); chk("R2 clr zero", r, 32'h3);

        for (int n = 0; n < 64; n++) begin
            wr(12'(n * 16), (n == 7) ? 32'(n % 4) : 32'(4 + n % 4));
        end
        rd(12'h3F0, r); chk("R2 last window", r, 32'h7);

        // R3 R4 R5 table walk
        for (int i = 0; i < 9; i++) begin
            src_req = STEPS[i].req;
            idle(1);
            rd(A_STATUS, r);
            chk($sformatf("R4 step %0d status", i), r, 32'(STEPS[i].vec));
            chk($sformatf("R3 step %0d irq", i), 32'(irq), 32'(STEPS[i].irq));
        end

        // R6 R7 R8 nesting
        src_req = 64'h40; idle(2);
        chk("R3 irq src6", 32'(irq), 32'd1);
        wr(A_VECTOR, 32'hDEAD);
        chk("R6 irq drop", 32'(irq), 32'd0);
        idle(3);
        chk("R7 held low", 32'(irq), 32'd0);
        rd(A_STATUS, r); chk("R7 status masked", r, 32'h7F);
        src_req = 64'h460; idle(2);
        chk("R7 equal and lower masked", 32'(irq), 32'd0);
        src_req = 64'h468; idle(2);
        chk("R7 higher irq", 32'(irq), 32'd1);
        rd(A_STATUS, r); chk("R7 higher status", r, 32'h3);
        wr(A_VECTOR, 32'h0);
        chk("R6 second drop", 32'(irq), 32'd0);
        src_req = 64'h460; idle(2);
        wr(A_LVLACK, 32'h8); idle(2);
        chk("R8 level2 still held", 32'(irq), 32'd0);
        wr(A_LVLACK, 32'h4); idle(2);
        chk("R8 reselect irq", 32'(irq), 32'd1);
        rd(A_STATUS, r); chk("R8 reselect status", r, 32'h6);

        // R9 vector write with nothing valid
        wr(A_LVLACK, 32'hF);
        src_req = '0; idle(2);
        rd(A_STATUS, r); chk("R5 idle status", r, 32'h7F);
        chk("R5 idle irq", 32'(irq), 32'd0);
        wr(A_VECTOR, 32'h5); idle(1);
        src_req = 64'h10; idle(2);
        chk("R9 low prio irq", 32'(irq), 32'd1);
        rd(A_STATUS, r); chk("R9 status", r, 32'h4);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule